// File: doc/BRIEF.md
# Tagged Download Word Decoder

This block sits behind a USB bridge on the download path. It receives 16-bit words one at a time, qualified by a write strobe. The two-bit tag in bits 9:8 of each word says what the low byte means. An address word sets the target card and region. A command word sets the current command. A data word sends one byte out, together with the most recent address and command, as a single transaction toward a backplane serializer.

Words that do not follow the format are dropped. The fixed filler word 0xAAAA is a special case: it is discarded quietly and raises no error. Any other malformed word raises a one-cycle format error pulse. Address and command words change only the internal context registers and produce no output. All outputs are registered, so a result appears one clock after the word is accepted.

Top module: `dl_word_decoder`

## Requirements
- R1: After reset, `txn_valid` and `fmt_err` are 0, and the card, region and command context is all zero. The first data word after reset therefore reports card 0, region 0 and command 0.
- R2: An accepted word with bits 15:10 zero and tag bits 9:8 = 01 is an address word. Payload bits 7:4 become the card address and bits 3:0 become the region address. No transaction and no error follow.
- R3: An accepted word with bits 15:10 zero and tag 11 is a command word. Payload bits 7:0 become the current command. No transaction and no error follow.
- R4: An accepted word with bits 15:10 zero and tag 10 is a data word. On the next cycle `txn_valid` is 1 for exactly one cycle, `txn_data` equals bits 7:0, and card, region and command carry the context latched before that word.
- R5: The word 0xAAAA is dropped. It produces no transaction and no `fmt_err`, and it leaves the context unchanged.
- R6: Any word other than 0xAAAA with a nonzero value in bits 15:10 is dropped. `fmt_err` pulses on the next cycle, and the context is unchanged.
- R7: A word with bits 15:10 zero and tag 00 is dropped. `fmt_err` pulses on the next cycle, and the context is unchanged.
- R8: While `wr_en` is 0, the word bus is ignored. No transaction or error follows, and the context is unchanged.
- R9: Data words on back-to-back cycles each give their own transaction. A context word placed between two data words affects only the data words that come after it.
- R10: `txn_valid` and `fmt_err` are never both 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe; the word is taken on this clock edge |
| wr_word | input | 16 | Download word from the USB bridge |
| txn_valid | output | 1 | One-cycle transaction strobe |
| txn_card | output | 4 | Card address of the transaction |
| txn_region | output | 4 | Region address of the transaction |
| txn_cmd | output | 8 | Command of the transaction |
| txn_data | output | 8 | Data byte of the transaction |
| fmt_err | output | 1 | One-cycle pulse for a malformed word that was dropped |

## Verification
All 256 payload values are sent through each tag as address, command and data triples, with two data words back to back. This separates a wrong split of the address byte from a stale or swapped context. Every nonzero pattern of bits 15:10 is tried with both a data tag and an address tag. Each of these is followed by a valid data word, which shows that the error pulses and that the context stayed unchanged. The filler word is also compared against near neighbours: 0xAAAB must raise an error, and 0x02AA is valid data. Words sent with the strobe low, and tag-00 words, round out the drop cases.

// File: rtl/dlw_pkg.sv
// Package: shared word-kind encoding and tag codes for the download decoder.
// Assumes a two-bit tag sitting directly above the payload byte.
package dlw_pkg;
    typedef enum logic [2:0] {
        WK_IDLE   = 3'd0,
        WK_FILLER = 3'd1,
        WK_BAD    = 3'd2,
        WK_ADDR   = 3'd3,
        WK_CMD    = 3'd4,
        WK_DATA   = 3'd5
    } word_kind_e;

    localparam logic [1:0] TAG_ADDR = 2'b01;
    localparam logic [1:0] TAG_DATA = 2'b10;
    localparam logic [1:0] TAG_CMD  = 2'b11;
endpackage

// File: rtl/dlw_classifier.sv
// Module: dlw_classifier
// Purely combinational decode of one strobed word into a kind plus payload.
// Assumes the tag occupies the two bits just above the payload, and that any
// bits above the tag must be zero. The filler check is done first.
module dlw_classifier
    import dlw_pkg::*;
#(
    parameter int              WORD_W    = 16,
    parameter int              PAYLOAD_W = 8,
    parameter logic [WORD_W-1:0] FILLER  = 16'hAAAA
) (
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    word,
    output word_kind_e           kind,
    output logic [PAYLOAD_W-1:0] payload
);
    localparam int TAG_LSB = PAYLOAD_W;
    localparam int HI_LSB  = PAYLOAD_W + 2;

    logic       upper_clear;
    logic [1:0] tag;

    assign tag     = word[TAG_LSB +: 2];
    assign payload = word[PAYLOAD_W-1:0];

    // Upper-bit check exists only when the word is wider than tag plus payload.
    generate
        if (WORD_W > HI_LSB) begin : g_upper
            assign upper_clear = (word[WORD_W-1:HI_LSB] == '0);
        end else begin : g_no_upper
            assign upper_clear = 1'b1;
        end
    endgenerate

    // Decide the word kind, filler first, then format, then tag.
    always_comb begin
        kind = WK_IDLE;
        if (wr_en) begin
            if (word == FILLER) begin
                kind = WK_FILLER;
            end else if (!upper_clear) begin
                kind = WK_BAD;
            end else begin
                unique case (tag)
                    TAG_ADDR: kind = WK_ADDR;
                    TAG_CMD:  kind = WK_CMD;
                    TAG_DATA: kind = WK_DATA;
                    default:  kind = WK_BAD;
                endcase
            end
        end
    end
endmodule

// File: rtl/dlw_context.sv
// Module: dlw_context
// Holds the card, region and command context updated by address and command
// words. Assumes the card field is the upper CARD_W bits of the address byte.
module dlw_context
    import dlw_pkg::*;
#(
    parameter int PAYLOAD_W = 8,
    parameter int CARD_W    = 4,
    localparam int REGION_W = PAYLOAD_W - CARD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  word_kind_e           kind,
    input  logic [PAYLOAD_W-1:0] payload,
    output logic [CARD_W-1:0]    card,
    output logic [REGION_W-1:0]  region,
    output logic [PAYLOAD_W-1:0] cmd
);
    // Latch the address fields on an address word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            card   <= '0;
            region <= '0;
        end else if (kind == WK_ADDR) begin
            card   <= payload[PAYLOAD_W-1 -: CARD_W];
            region <= payload[REGION_W-1:0];
        end
    end

    // Latch the command byte on a command word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd <= '0;
        end else if (kind == WK_CMD) begin
            cmd <= payload;
        end
    end
endmodule

// File: rtl/dlw_txn_out.sv
// Module: dlw_txn_out
// Registers the outgoing transaction and the format-error pulse.
// Assumes the context inputs still hold the values from before the current
// word; a data word never changes them.
module dlw_txn_out
    import dlw_pkg::*;
#(
    parameter int PAYLOAD_W = 8,
    parameter int CARD_W    = 4,
    localparam int REGION_W = PAYLOAD_W - CARD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  word_kind_e           kind,
    input  logic [PAYLOAD_W-1:0] payload,
    input  logic [CARD_W-1:0]    ctx_card,
    input  logic [REGION_W-1:0]  ctx_region,
    input  logic [PAYLOAD_W-1:0] ctx_cmd,
    output logic                 txn_valid,
    output logic [CARD_W-1:0]    txn_card,
    output logic [REGION_W-1:0]  txn_region,
    output logic [PAYLOAD_W-1:0] txn_cmd,
    output logic [PAYLOAD_W-1:0] txn_data,
    output logic                 fmt_err
);
    // One-cycle strobes for a transaction and for a dropped malformed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txn_valid <= 1'b0;
            fmt_err   <= 1'b0;
        end else begin
            txn_valid <= (kind == WK_DATA);
            fmt_err   <= (kind == WK_BAD);
        end
    end

    // Capture the transaction fields on a data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txn_card   <= '0;
            txn_region <= '0;
            txn_cmd    <= '0;
            txn_data   <= '0;
        end else if (kind == WK_DATA) begin
            txn_card   <= ctx_card;
            txn_region <= ctx_region;
            txn_cmd    <= ctx_cmd;
            txn_data   <= payload;
        end
    end
endmodule

// File: rtl/dl_word_decoder.sv
// Module: dl_word_decoder
// Top of the download word decoder: classify, update context, emit.
// Assumes one word per strobed cycle. The outputs lag the input word by one clock.
module dl_word_decoder
    import dlw_pkg::*;
#(
    parameter int                WORD_W    = 16,
    parameter int                PAYLOAD_W = 8,
    parameter int                CARD_W    = 4,
    parameter logic [WORD_W-1:0] FILLER    = 16'hAAAA,
    localparam int               REGION_W  = PAYLOAD_W - CARD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_word,
    output logic                 txn_valid,
    output logic [CARD_W-1:0]    txn_card,
    output logic [REGION_W-1:0]  txn_region,
    output logic [PAYLOAD_W-1:0] txn_cmd,
    output logic [PAYLOAD_W-1:0] txn_data,
    output logic                 fmt_err
);
    word_kind_e           kind;
    logic [PAYLOAD_W-1:0] payload;
    logic [CARD_W-1:0]    ctx_card;
    logic [REGION_W-1:0]  ctx_region;
    logic [PAYLOAD_W-1:0] ctx_cmd;

    dlw_classifier #(
        .WORD_W(WORD_W), .PAYLOAD_W(PAYLOAD_W), .FILLER(FILLER)
    ) cls_i (
        .wr_en(wr_en), .word(wr_word), .kind(kind), .payload(payload)
    );

    dlw_context #(
        .PAYLOAD_W(PAYLOAD_W), .CARD_W(CARD_W)
    ) ctx_i (
        .clk(clk), .rst_n(rst_n), .kind(kind), .payload(payload),
        .card(ctx_card), .region(ctx_region), .cmd(ctx_cmd)
    );

    dlw_txn_out #(
        .PAYLOAD_W(PAYLOAD_W), .CARD_W(CARD_W)
    ) out_i (
        .clk(clk), .rst_n(rst_n), .kind(kind), .payload(payload),
        .ctx_card(ctx_card), .ctx_region(ctx_region), .ctx_cmd(ctx_cmd),
        .txn_valid(txn_valid), .txn_card(txn_card), .txn_region(txn_region),
        .txn_cmd(txn_cmd), .txn_data(txn_data), .fmt_err(fmt_err)
    );
endmodule

// File: rtl/dl_word_decoder_chk.sv
// Module: dl_word_decoder_chk
// Port-level checker for the download word decoder, bound to the top.
// Assumes the default geometry: 16-bit word, byte payload, 4-bit card field.
module dl_word_decoder_chk #(
    parameter int                WORD_W    = 16,
    parameter int                PAYLOAD_W = 8,
    parameter int                CARD_W    = 4,
    parameter logic [WORD_W-1:0] FILLER    = 16'hAAAA,
    localparam int               REGION_W  = PAYLOAD_W - CARD_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [WORD_W-1:0]    wr_word,
    input logic                 txn_valid,
    input logic [CARD_W-1:0]    txn_card,
    input logic [REGION_W-1:0]  txn_region,
    input logic [PAYLOAD_W-1:0] txn_cmd,
    input logic [PAYLOAD_W-1:0] txn_data,
    input logic                 fmt_err
);
    logic       hi_zero;
    logic [1:0] tg;
    logic       is_fill;
    assign hi_zero = ((wr_word >> (PAYLOAD_W + 2)) == '0);
    assign tg      = wr_word[PAYLOAD_W +: 2];
    assign is_fill = (wr_word == FILLER);

    a_r4_data_txn: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_fill && hi_zero && tg == 2'b10)
        |=> (txn_valid && txn_data == $past(wr_word[PAYLOAD_W-1:0])));

    a_r2_addr_split: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hi_zero && tg == 2'b01)
        |=> ((wr_en && !is_fill && hi_zero && tg == 2'b10)
        |=> (txn_card == $past(wr_word[PAYLOAD_W-1 -: CARD_W], 2)
             && txn_region == $past(wr_word[REGION_W-1:0], 2))));

    a_r5_filler_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_fill) |=> (!txn_valid && !fmt_err));

    a_r6_upper_err: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_fill && !hi_zero) |=> (fmt_err && !txn_valid));

    a_r7_tag00_err: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hi_zero && tg == 2'b00) |=> (fmt_err && !txn_valid));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> (!txn_valid && !fmt_err));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(txn_valid && fmt_err));
endmodule

bind dl_word_decoder dl_word_decoder_chk chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .txn_valid(txn_valid), .txn_card(txn_card), .txn_region(txn_region),
    .txn_cmd(txn_cmd), .txn_data(txn_data), .fmt_err(fmt_err)
);

// File: tb/dl_word_decoder_tb_top.sv
`timescale 1ns/1ps
module dl_word_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_word = '0;
    logic        txn_valid, fmt_err;
    logic [3:0]  txn_card, txn_region;
    logic [7:0]  txn_cmd, txn_data;

    int n_run  = 0;
    int n_fail = 0;

    // Reference context kept by the bench from the requirements.
    logic [3:0] m_card = '0;
    logic [3:0] m_region = '0;
    logic [7:0] m_cmd = '0;

    always #2.5 clk = ~clk;

    dl_word_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .txn_valid(txn_valid), .txn_card(txn_card), .txn_region(txn_region),
        .txn_cmd(txn_cmd), .txn_data(txn_data), .fmt_err(fmt_err)
    );

    // Drive one word at a falling edge, then check the outputs at the next falling edge.
    task automatic step(input logic en, input logic [15:0] w, input string req);
        logic ev, ee;
        logic [7:0] ed;
        ev = 1'b0; ee = 1'b0; ed = w[7:0];
        wr_en = en; wr_word = w;
        @(negedge clk);
        wr_en = 1'b0;
        if (en && w != 16'hAAAA) begin
            if (w[15:10] != 6'd0) ee = 1'b1;
            else if (w[9:8] == 2'b10) ev = 1'b1;
            else if (w[9:8] == 2'b00) ee = 1'b1;
        end
        n_run++;
        if (txn_valid !== ev || fmt_err !== ee ||
            (ev && (txn_card !== m_card || txn_region !== m_region ||
                    txn_cmd !== m_cmd || txn_data !== ed))) begin
            n_fail++;
            $display("FAIL %s word=%h: got v=%0b e=%0b c=%h r=%h m=%h d=%h exp v=%0b e=%0b c=%h r=%h m=%h d=%h",
                     req, w, txn_valid, fmt_err, txn_card, txn_region, txn_cmd, txn_data,
                     ev, ee, m_card, m_region, m_cmd, ed);
        end
        if (en && w[15:10] == 6'd0) begin
            if (w[9:8] == 2'b01) begin m_card = w[7:4]; m_region = w[3:0]; end
            if (w[9:8] == 2'b11) m_cmd = w[7:0];
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got running exp done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        n_run++;
        if (txn_valid !== 1'b0 || fmt_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 in reset: got v=%0b e=%0b exp 0 0", txn_valid, fmt_err);
        end
        rst_n = 1'b1;
        @(negedge clk);
        step(1'b1, 16'h0277, "R1 first data after reset");

        // R2 R3 R4 R9: sweep every payload through all three tags.
        for (int i = 0; i < 256; i++) begin
            step(1'b1, {8'h01, i[7:0]}, "R2 address");
            step(1'b1, {8'h03, 8'(255 - i)}, "R3 command");
            step(1'b1, {8'h02, 8'(i ^ 8'h5A)}, "R4 data");
            step(1'b1, {8'h02, 8'(i + 3)}, "R9 back-to-back data");
        end

        // R9: context change between data words.
        step(1'b1, 16'h02C1, "R9 data before change");
        step(1'b1, 16'h013C, "R9 address change");
        step(1'b1, 16'h02C2, "R9 data after change");

        // R6: every nonzero upper pattern, data and address tags.
        for (int u = 1; u < 64; u++) begin
            step(1'b1, {u[5:0], 2'b10, 8'h33}, "R6 upper bits data tag");
            step(1'b1, {u[5:0], 2'b01, 8'hE7}, "R6 upper bits addr tag");
            step(1'b1, 16'h0211, "R6 context unchanged");
        end

        // R7: tag 00 dropped.
        for (int p = 0; p < 256; p += 17) begin
            step(1'b1, {8'h00, p[7:0]}, "R7 tag 00");
            step(1'b1, 16'h0244, "R7 context unchanged");
        end

        // R5: filler and its neighbours.
        step(1'b1, 16'hAAAA, "R5 filler");
        step(1'b1, 16'h0255, "R5 context unchanged");
        step(1'b1, 16'hAAAB, "R6 filler neighbour");
        step(1'b1, 16'h02AA, "R5 low bits of filler are data");

        // R8: strobe low ignores the bus.
        step(1'b0, 16'h0202, "R8 idle data");
        step(1'b0, 16'h01FF, "R8 idle address");
        step(1'b0, 16'h03EE, "R8 idle command");
        step(1'b0, 16'hFFFF, "R8 idle bad");
        step(1'b1, 16'h0266, "R8 context unchanged");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule